// File: doc/BRIEF.md
# Radix-5 Digit-Reversal Output Reorder

This block follows a pipelined 25-point radix-5 FFT and restores natural frequency order to its results. The FFT emits each frame as 25 complex samples on back-to-back clock cycles, and it flags the first one with a start pulse. Each frame is captured into one half of a two-bank buffer. The previously captured frame is replayed from the other half at the same time.

The index of a sample is a two-digit base-5 number, written hi*5 + lo. The replay walks output positions 0 to 24 in order. For each position it fetches the stored sample whose two digits are exchanged. The storage uses small memories with a registered read port. Each replayed frame leaves as an unbroken 25-cycle burst. The burst carries its own start flag. Outside a burst, the outputs rest at zero.

Top module: `radix5Reorder`

## Requirements
- R1: After reset, outStart is low and outRe and outIm are zero until the first complete frame is replayed.
- R2: A start pulse marks the sample presented with it as index 0 of a new frame and switches the capture bank. A frame that a new start pulse interrupts before its 25th sample is discarded and produces no output.
- R3: Output position k = 5*a + b (high digit a, low digit b, both 0 to 4) carries the input sample of index 5*b + a of the same frame.
- R4: If a frame's index-0 sample is presented in cycle c, its output position 0 appears in cycle c+26. No output of that frame appears earlier.
- R5: outStart is high in the cycle of output position 0 and low for the other 24 positions.
- R6: The 25 output positions of a frame appear on 25 consecutive cycles.
- R7: Frames arriving back to back, each start 25 cycles after the previous one, are all reordered correctly. No sample leaks between frames.
- R8: Outside a replay burst, outRe and outIm are zero and outStart is low.
- R9: The real and imaginary words are carried independently at full signed width. Values at the extremes of the range, both most negative and most positive, pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inStart | input | 1 | High with index 0 of each incoming frame |
| inRe | input | DATA_W | Real part of the incoming sample, signed |
| inIm | input | DATA_W | Imaginary part of the incoming sample, signed |
| outStart | output | 1 | High with output position 0 of each replayed frame |
| outRe | output | DATA_W | Real part of the reordered sample, signed |
| outIm | output | DATA_W | Imaginary part of the reordered sample, signed |

## Verification
Output position k of a frame is due exactly 26+k cycles after that frame's index-0 sample is presented. The 26 cycles are 25 capture cycles plus one registered read. The bench counts clock edges and records every output value against its edge count. Each check then looks up the cycle predicted by that formula, and the quiet cycles just before a burst and just after it. A frame aborted by an early start pulse is checked by confirming that the output stays idle for every cycle up to the replacement frame's predicted position 0.

// File: rtl/reorderPkg.sv
package reorderPkg;
  localparam int RADIX     = 5;
  localparam int FRAME_LEN = RADIX * RADIX;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int DIG_W     = $clog2(RADIX);
  localparam int MEM_DEPTH = 1 << IDX_W;

  typedef struct packed {
    logic             wrEn;
    logic             wrBank;
    logic [IDX_W-1:0] wrAddr;
    logic             rdEn;
    logic             rdBank;
    logic [IDX_W-1:0] rdAddr;
    logic             rdFirst;
  } strobeT;
endpackage

// File: rtl/reorderCtrl.sv
module reorderCtrl
  import reorderPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   inStart,
  output strobeT stb
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] RADIX_I  = IDX_W'(RADIX);
  localparam logic [DIG_W-1:0] LAST_DIG = DIG_W'(RADIX - 1);

  logic [IDX_W-1:0] wrIdx;
  logic             wrBusy;
  logic             bankReg;
  logic [DIG_W-1:0] rdHi;
  logic [DIG_W-1:0] rdLo;
  logic             rdBusy;
  logic             rdBankReg;

  logic             wrNow;
  logic [IDX_W-1:0] wrAddrNow;
  logic             wrBankNow;
  logic             lastWrite;

  always_comb begin
    wrNow     = inStart || wrBusy;
    wrAddrNow = inStart ? '0 : wrIdx;
    wrBankNow = inStart ? ~bankReg : bankReg;
    lastWrite = wrNow && (wrAddrNow == LAST_IDX);
  end

  // capture side: index counter and bank toggle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrIdx   <= '0;
      wrBusy  <= 1'b0;
      bankReg <= 1'b0;
    end else if (inStart) begin
      bankReg <= ~bankReg;
      wrBusy  <= 1'b1;
      wrIdx   <= IDX_W'(1);
    end else if (wrBusy) begin
      if (wrIdx == LAST_IDX) begin
        wrBusy <= 1'b0;
        wrIdx  <= '0;
      end else begin
        wrIdx <= wrIdx + IDX_W'(1);
      end
    end
  end

  // replay side: two base-RADIX digits, low digit fastest
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdHi      <= '0;
      rdLo      <= '0;
      rdBusy    <= 1'b0;
      rdBankReg <= 1'b0;
    end else if (lastWrite) begin
      rdBusy    <= 1'b1;
      rdHi      <= '0;
      rdLo      <= '0;
      rdBankReg <= wrBankNow;
    end else if (rdBusy) begin
      if (rdLo == LAST_DIG) begin
        rdLo <= '0;
        if (rdHi == LAST_DIG) begin
          rdBusy <= 1'b0;
          rdHi   <= '0;
        end else begin
          rdHi <= rdHi + DIG_W'(1);
        end
      end else begin
        rdLo <= rdLo + DIG_W'(1);
      end
    end
  end

  always_comb begin
    stb.wrEn    = wrNow;
    stb.wrBank  = wrBankNow;
    stb.wrAddr  = wrAddrNow;
    stb.rdEn    = rdBusy;
    stb.rdBank  = rdBankReg;
    stb.rdAddr  = IDX_W'(rdLo) * RADIX_I + IDX_W'(rdHi);
    stb.rdFirst = rdBusy && (rdHi == '0) && (rdLo == '0);
  end

  // R7: capture and replay never share a bank
  p_bank_split_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrEn && stb.rdEn) |-> (stb.wrBank != stb.rdBank));

  // R4: a replay only begins right after the last sample is captured
  p_read_follows_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stb.rdEn) |-> $past(stb.wrEn && (stb.wrAddr == LAST_IDX)));

  // R2: the index following a start pulse is 1
  p_wr_restart_r2: assert property (@(posedge clk) disable iff (!rstN)
    inStart |=> (inStart || (stb.wrAddr == IDX_W'(1))));

  // R3: swapped address stays inside a frame
  p_rdaddr_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdEn |-> (stb.rdAddr < IDX_W'(FRAME_LEN)));
endmodule

// File: rtl/reorderData.sv
module reorderData
  import reorderPkg::*;
#(
  parameter int DATA_W = 22
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobeT                   stb,
  input  logic signed [DATA_W-1:0] inRe,
  input  logic signed [DATA_W-1:0] inIm,
  output logic                     outStart,
  output logic signed [DATA_W-1:0] outRe,
  output logic signed [DATA_W-1:0] outIm
);
  localparam int WORD_W = 2 * DATA_W;

  logic [WORD_W-1:0] bankWord [2];
  logic [WORD_W-1:0] outWord;
  logic              outValid;

  for (genvar b = 0; b < 2; b++) begin : gBank
    logic [WORD_W-1:0] mem [MEM_DEPTH];
    always_ff @(posedge clk) begin
      if (stb.wrEn && (stb.wrBank == 1'(b)))
        mem[stb.wrAddr] <= {inRe, inIm};
    end
    assign bankWord[b] = mem[stb.rdAddr];
  end

  // registered read port; zero outside a burst
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outWord  <= '0;
      outValid <= 1'b0;
      outStart <= 1'b0;
    end else begin
      outValid <= stb.rdEn;
      outStart <= stb.rdFirst;
      outWord  <= stb.rdEn ? bankWord[stb.rdBank] : '0;
    end
  end

  assign outRe = outWord[WORD_W-1:DATA_W];
  assign outIm = outWord[DATA_W-1:0];

  // R5: the start flag only marks a sample inside a burst
  p_start_in_burst_r5: assert property (@(posedge clk) disable iff (!rstN)
    outStart |-> outValid);

  // R6: the burst continues after its first sample
  p_burst_continues_r6: assert property (@(posedge clk) disable iff (!rstN)
    outStart |=> (outValid && !outStart));

  // R8: idle output is zero
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ((outRe == '0) && (outIm == '0) && !outStart));
endmodule

// File: rtl/radix5Reorder.sv
module radix5Reorder
  import reorderPkg::*;
#(
  parameter int DATA_W = 22
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inStart,
  input  logic signed [DATA_W-1:0] inRe,
  input  logic signed [DATA_W-1:0] inIm,
  output logic                     outStart,
  output logic signed [DATA_W-1:0] outRe,
  output logic signed [DATA_W-1:0] outIm
);
  strobeT stb;

  reorderCtrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .inStart (inStart),
    .stb     (stb)
  );

  reorderData #(.DATA_W(DATA_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .inRe     (inRe),
    .inIm     (inIm),
    .outStart (outStart),
    .outRe    (outRe),
    .outIm    (outIm)
  );
endmodule

// File: tb/radix5Reorder_test.sv
module radix5Reorder_test;
  localparam int DW   = 22;
  localparam int LOGN = 4096;
  localparam int FL   = 25;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inStart = 1'b0;
  logic signed [DW-1:0] inRe = '0;
  logic signed [DW-1:0] inIm = '0;
  logic outStart;
  logic signed [DW-1:0] outRe;
  logic signed [DW-1:0] outIm;

  int cyc = 0;
  int nChk = 0;
  int nFail = 0;

  logic signed [DW-1:0] srcRe [8][FL];
  logic signed [DW-1:0] srcIm [8][FL];
  logic                 logSt [LOGN];
  logic signed [DW-1:0] logRe [LOGN];
  logic signed [DW-1:0] logIm [LOGN];

  radix5Reorder #(.DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .inStart(inStart), .inRe(inRe), .inIm(inIm),
    .outStart(outStart), .outRe(outRe), .outIm(outIm)
  );

  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (cyc < LOGN) begin
      logSt[cyc] = outStart;
      logRe[cyc] = outRe;
      logIm[cyc] = outIm;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic fillFrame(input int f, input bit extreme);
    for (int i = 0; i < FL; i++) begin
      if (extreme) begin
        srcRe[f][i] = (i % 2 == 0) ? DW'(-(1 << (DW-1)) + i * 3) : DW'((1 << (DW-1)) - 1 - i);
        srcIm[f][i] = (i % 2 == 0) ? DW'((1 << (DW-1)) - 1 - i) : DW'(-(1 << (DW-1)) + i * 5);
      end else begin
        srcRe[f][i] = DW'(f * 1000 + i * 41 - 30000);
        srcIm[f][i] = DW'(12345 - f * 777 + i * 13);
      end
    end
  endtask

  task automatic driveFrame(input int f, input int n, output int s);
    s = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 0) s = cyc;
      inStart = (i == 0);
      inRe = srcRe[f][i];
      inIm = srcIm[f][i];
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inStart = 1'b0;
      inRe = '0;
      inIm = '0;
    end
  endtask

  // checks R3, R5 and R6 for one frame whose index 0 was presented in cycle s
  task automatic checkFrame(input int f, input int s, input string tag);
    for (int k = 0; k < FL; k++) begin
      int src = (k % 5) * 5 + k / 5;
      int c = s + 26 + k;
      check(logSt[c] == (k == 0), {tag, " R5 start flag"}, longint'(logSt[c]), longint'(k == 0));
      check(logRe[c] == srcRe[f][src], {tag, " R3 R6 real"}, longint'(logRe[c]), longint'(srcRe[f][src]));
      check(logIm[c] == srcIm[f][src], {tag, " R3 R6 imag"}, longint'(logIm[c]), longint'(srcIm[f][src]));
    end
  endtask

  task automatic checkQuiet(input int c, input string tag);
    check(!logSt[c] && logRe[c] == '0 && logIm[c] == '0, tag,
          longint'(logRe[c]) + longint'(logSt[c]), 0);
  endtask

  task automatic testReset;
    idle(5);
    for (int c = 1; c < 5; c++) checkQuiet(c, "R1 reset idle");
  endtask

  task automatic testSingle;
    int s;
    fillFrame(0, 1'b0);
    driveFrame(0, FL, s);
    idle(60);
    checkQuiet(s + 25, "R4 no early output");
    checkFrame(0, s, "single R4");
    checkQuiet(s + 51, "R8 idle after burst");
    checkQuiet(s + 60, "R8 idle later");
  endtask

  task automatic testBackToBack;
    int s1, s2, s3;
    fillFrame(1, 1'b0);
    fillFrame(2, 1'b0);
    fillFrame(3, 1'b0);
    driveFrame(1, FL, s1);
    driveFrame(2, FL, s2);
    driveFrame(3, FL, s3);
    idle(60);
    checkFrame(1, s1, "R7 frame1");
    checkFrame(2, s2, "R7 frame2");
    checkFrame(3, s3, "R7 frame3");
    checkQuiet(s3 + 51, "R8 after train");
  endtask

  task automatic testExtreme;
    int s;
    fillFrame(4, 1'b1);
    driveFrame(4, FL, s);
    idle(60);
    checkFrame(4, s, "R9 extremes");
  endtask

  task automatic testRestart;
    int s0, s1;
    fillFrame(5, 1'b0);
    fillFrame(6, 1'b0);
    driveFrame(5, 10, s0);
    driveFrame(6, FL, s1);
    idle(60);
    for (int c = s0 + 1; c < s1 + 26; c++) checkQuiet(c, "R2 aborted frame silent");
    checkFrame(6, s1, "R2 restarted frame");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testSingle();
    testBackToBack();
    testExtreme();
    testRestart();
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    nChk++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule